// File: doc/BRIEF.md
# Serial NOR Flash Command Responder

This block is a single-lane SPI target that acts like a small serial NOR flash. A flash host controller under test talks to it. The block oversamples the serial clock, select and data-in lines with its own system clock. It takes an 8-bit command, then the address bytes and dummy clocks that command needs. After that it either streams bytes out on the data-out line or collects bytes into a 256-byte page buffer.

The responder keeps a write-enable latch, a status byte and an address-width mode. The address width is three bytes after reset and can be switched to four at run time. Behind the command logic sits a byte array, which is blank (all FFh) after reset. A walking engine applies program and erase jobs to the array one byte per clock. It keeps the busy flag raised for a fixed minimum time after each job.

The block changes data-out shortly after each serial clock rising edge. Hosts therefore sample data-out just before they raise the serial clock.

Top module: `flash_resp`

## Requirements
- R1: After reset, data-out is 0, the status byte reads 00h, every array byte reads FFh and the address width is three bytes.
- R2: Commands, addresses and data shift most significant bit first. The target samples data-in on each serial clock rising edge and updates data-out after it.
- R3: Command 03h takes an address and then returns array bytes from consecutive addresses until select rises. The address wraps modulo the array size.
- R4: Command 0Bh takes an address, then 8 dummy clocks, then streams array bytes like 03h.
- R5: Command 05h returns the live status byte on every byte slot until select rises. Bit 0 is busy and bit 1 is the write-enable latch.
- R6: Command 06h sets the write-enable latch and 04h clears it. Neither takes an address.
- R7: B7h makes 03h, 0Bh, 02h and D8h take four address bytes, and E9h returns them to three. 20h always takes three.
- R8: Command 02h stores each data byte at page column (start column + n) mod 256 of the addressed 256-byte page. The new value is old AND new. When more than 256 bytes arrive, only the last 256 take effect.
- R9: 20h erases the aligned 128-byte subsector, D8h the aligned 512-byte sector and C7h the whole array, all to FFh.
- R10: Program and erase commands take effect only if the write-enable latch is set when select rises. Committing one clears the latch.
- R11: Busy rises when a job is committed and stays high for at least BUSY_CLKS clocks and until the job is done. A program or erase that ends while busy is ignored.
- R12: If select rises part-way through a byte, the command is aborted. A pending program is not committed and the latch stays set.
- R13: Command 9Fh returns the three ID_WORD bytes, high byte first, then 00h for the rest of the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_clk | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low select from the host |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |

## Verification
The bench sends a page write of 258 bytes. A page buffer that did not wrap would spill into the next page or keep the first bytes instead of the last. The bench overwrites a programmed byte: a design that stores plain data instead of the AND would show the new value. It erases in subsector, sector and bulk sizes and probes just inside and just outside each boundary, which catches wrong alignment masks. It also switches address width, issues a program while busy, and raises select mid-byte. These catch a design that miscounts address bytes, commits a blocked job, or commits a torn write.

// File: rtl/flash_pkg.sv
package flash_pkg;
    typedef enum logic [2:0] {
        PH_OPC, PH_ADDR, PH_DUMMY, PH_DOUT, PH_DIN, PH_HOLD
    } phase_e;

    typedef enum logic [1:0] {SRC_MEM, SRC_STAT, SRC_ID} src_e;

    localparam logic [7:0] CMD_READ   = 8'h03;
    localparam logic [7:0] CMD_FAST   = 8'h0B;
    localparam logic [7:0] CMD_STAT   = 8'h05;
    localparam logic [7:0] CMD_ID     = 8'h9F;
    localparam logic [7:0] CMD_WEN    = 8'h06;
    localparam logic [7:0] CMD_WDIS   = 8'h04;
    localparam logic [7:0] CMD_PROG   = 8'h02;
    localparam logic [7:0] CMD_SECT   = 8'hD8;
    localparam logic [7:0] CMD_SUB    = 8'h20;
    localparam logic [7:0] CMD_BULK   = 8'hC7;
    localparam logic [7:0] CMD_WIDE   = 8'hB7;
    localparam logic [7:0] CMD_NARROW = 8'hE9;
endpackage

// File: rtl/flash_sync.sv
module flash_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    input  logic mosi,
    output logic rise,
    output logic sel,
    output logic cs_rise,
    output logic bit_in
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic c1;
        logic c2;
        logic m1;
    } smp_t;

    smp_t r_d, r_q;

    always_comb begin
        r_d.s1 = sclk;
        r_d.s2 = r_q.s1;
        r_d.c1 = cs_n;
        r_d.c2 = r_q.c1;
        r_d.m1 = mosi;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{s1: 1'b0, s2: 1'b0, c1: 1'b1, c2: 1'b1, m1: 1'b0};
        else        r_q <= r_d;
    end

    assign rise    = r_q.s1 & ~r_q.s2 & ~r_q.c1;
    assign sel     = ~r_q.c1;
    assign cs_rise = r_q.c1 & ~r_q.c2;
    assign bit_in  = r_q.m1;
endmodule

// File: rtl/flash_mem.sv
module flash_mem #(
    parameter int NUM_BYTES = 1024,
    parameter int BUSY_CLKS = 1000,
    localparam int AW = $clog2(NUM_BYTES),
    localparam int HW = $clog2(BUSY_CLKS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata,
    input  logic          pb_clr,
    input  logic          pb_we,
    input  logic [7:0]    pb_idx,
    input  logic [7:0]    pb_data,
    input  logic          start,
    input  logic          job_prog,
    input  logic [AW-1:0] job_base,
    input  logic [AW-1:0] job_last,
    output logic          busy
);
    typedef struct packed {
        logic          walk;
        logic          prog;
        logic [AW-1:0] idx;
        logic [AW-1:0] last;
        logic [AW-1:0] base;
        logic [HW-1:0] hold;
    } eng_t;

    eng_t e_d, e_q;

    logic [7:0]    mem   [NUM_BYTES];
    logic [7:0]    pbuf  [256];
    logic [255:0]  pval_q;
    logic [AW-1:0] waddr;
    logic [7:0]    wdata;

    always_comb begin
        e_d = e_q;
        if (e_q.hold != '0) e_d.hold = e_q.hold - 1'b1;
        if (e_q.walk) begin
            e_d.idx = e_q.idx + 1'b1;
            if (e_q.idx == e_q.last) e_d.walk = 1'b0;
        end
        if (start) begin
            e_d.walk = 1'b1;
            e_d.prog = job_prog;
            e_d.idx  = '0;
            e_d.last = job_last;
            e_d.base = job_base;
            e_d.hold = HW'(BUSY_CLKS);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_q <= '0;
        else        e_q <= e_d;
    end

    assign waddr = e_q.base + e_q.idx;

    always_comb begin
        if (!e_q.prog)                 wdata = 8'hFF;
        else if (pval_q[e_q.idx[7:0]]) wdata = mem[waddr] & pbuf[e_q.idx[7:0]];
        else                           wdata = mem[waddr];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_BYTES; i++) mem[i] <= 8'hFF;
        end else if (e_q.walk) begin
            mem[waddr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (pb_we) pbuf[pb_idx] <= pb_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      pval_q <= '0;
        else if (pb_clr) pval_q <= '0;
        else if (pb_we)  pval_q[pb_idx] <= 1'b1;
    end

    assign rdata = mem[raddr];
    assign busy  = e_q.walk | (e_q.hold != '0);
endmodule

// File: rtl/flash_resp.sv
module flash_resp #(
    parameter int          NUM_BYTES  = 1024,
    parameter int          SUB_BYTES  = 128,
    parameter int          SECT_BYTES = 512,
    parameter int          BUSY_CLKS  = 1000,
    parameter logic [23:0] ID_WORD    = 24'h5A310A
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_clk,
    input  logic spi_cs_n,
    input  logic spi_mosi,
    output logic spi_miso
);
    import flash_pkg::*;

    localparam int AW = $clog2(NUM_BYTES);
    localparam logic [AW-1:0] SUB_LAST  = AW'(SUB_BYTES - 1);
    localparam logic [AW-1:0] SECT_LAST = AW'(SECT_BYTES - 1);
    localparam logic [AW-1:0] ALL_LAST  = AW'(NUM_BYTES - 1);

    typedef struct packed {
        phase_e        phase;
        logic [7:0]    op;
        logic [6:0]    sh;
        logic [2:0]    bitn;
        logic [1:0]    acnt;
        logic [31:0]   addr;
        logic [AW-1:0] ptr;
        logic [7:0]    col;
        logic          got;
        logic [7:0]    tx;
        src_e          src;
        logic [1:0]    idn;
        logic          wel;
        logic          wide;
    } st_t;

    st_t s_d, s_q;

    logic          rise, sel, cs_rise, bit_in;
    logic [AW-1:0] raddr;
    logic [7:0]    rdata;
    logic          pb_clr, pb_we;
    logic [7:0]    pb_idx, pb_data;
    logic          start, job_prog;
    logic [AW-1:0] job_base, job_last;
    logic          busy;
    logic [7:0]    byte_now, status;
    logic [31:0]   addr_new;
    logic          wel_w;

    flash_sync u_sync (
        .clk(clk), .rst_n(rst_n), .sclk(spi_clk), .cs_n(spi_cs_n), .mosi(spi_mosi),
        .rise(rise), .sel(sel), .cs_rise(cs_rise), .bit_in(bit_in)
    );

    flash_mem #(.NUM_BYTES(NUM_BYTES), .BUSY_CLKS(BUSY_CLKS)) u_mem (
        .clk(clk), .rst_n(rst_n), .raddr(raddr), .rdata(rdata),
        .pb_clr(pb_clr), .pb_we(pb_we), .pb_idx(pb_idx), .pb_data(pb_data),
        .start(start), .job_prog(job_prog), .job_base(job_base),
        .job_last(job_last), .busy(busy)
    );

    assign byte_now = {s_q.sh, bit_in};
    assign addr_new = {s_q.addr[23:0], byte_now};
    assign status   = {6'b0, s_q.wel, busy};

    function automatic logic [7:0] id_byte(input logic [1:0] n);
        case (n)
            2'd0:    return ID_WORD[23:16];
            2'd1:    return ID_WORD[15:8];
            2'd2:    return ID_WORD[7:0];
            default: return 8'h00;
        endcase
    endfunction

    always_comb begin
        s_d      = s_q;
        raddr    = s_q.ptr;
        pb_clr   = 1'b0;
        pb_we    = 1'b0;
        pb_idx   = s_q.col;
        pb_data  = byte_now;
        start    = 1'b0;
        job_prog = 1'b0;
        job_base = '0;
        job_last = ALL_LAST;

        // commit on select release, byte aligned only
        if (cs_rise && s_q.bitn == 3'd0 && s_q.wel && !busy) begin
            if (s_q.phase == PH_DIN && s_q.op == CMD_PROG && s_q.got) begin
                start    = 1'b1;
                job_prog = 1'b1;
                job_base = {s_q.addr[AW-1:8], 8'h00};
                job_last = AW'(255);
                s_d.wel  = 1'b0;
            end else if (s_q.phase == PH_HOLD) begin
                case (s_q.op)
                    CMD_BULK: begin
                        start = 1'b1; s_d.wel = 1'b0;
                        job_base = '0; job_last = ALL_LAST;
                    end
                    CMD_SECT: begin
                        start = 1'b1; s_d.wel = 1'b0;
                        job_base = s_q.addr[AW-1:0] & ~SECT_LAST; job_last = SECT_LAST;
                    end
                    CMD_SUB: begin
                        start = 1'b1; s_d.wel = 1'b0;
                        job_base = s_q.addr[AW-1:0] & ~SUB_LAST; job_last = SUB_LAST;
                    end
                    default: ;
                endcase
            end
        end

        if (!sel) begin
            s_d.phase = PH_OPC;
            s_d.bitn  = '0;
            s_d.acnt  = '0;
            s_d.addr  = '0;
            s_d.tx    = '0;
            s_d.idn   = '0;
            s_d.got   = 1'b0;
        end else if (rise) begin
            s_d.bitn = s_q.bitn + 1'b1;
            s_d.sh   = byte_now[6:0];
            s_d.tx   = {s_q.tx[6:0], 1'b0};
            if (s_q.bitn == 3'd7) begin
                case (s_q.phase)
                    PH_OPC: begin
                        s_d.op    = byte_now;
                        s_d.phase = PH_HOLD;
                        case (byte_now)
                            CMD_READ, CMD_FAST, CMD_SECT: begin
                                s_d.phase = PH_ADDR;
                                s_d.acnt  = s_q.wide ? 2'd3 : 2'd2;
                            end
                            CMD_PROG: begin
                                s_d.phase = PH_ADDR;
                                s_d.acnt  = s_q.wide ? 2'd3 : 2'd2;
                                pb_clr    = 1'b1;
                            end
                            CMD_SUB: begin
                                s_d.phase = PH_ADDR;
                                s_d.acnt  = 2'd2;
                            end
                            CMD_STAT: begin
                                s_d.phase = PH_DOUT; s_d.src = SRC_STAT; s_d.tx = status;
                            end
                            CMD_ID: begin
                                s_d.phase = PH_DOUT; s_d.src = SRC_ID;
                                s_d.tx = id_byte(2'd0); s_d.idn = 2'd1;
                            end
                            CMD_WEN:    s_d.wel  = 1'b1;
                            CMD_WDIS:   s_d.wel  = 1'b0;
                            CMD_WIDE:   s_d.wide = 1'b1;
                            CMD_NARROW: s_d.wide = 1'b0;
                            default: ;
                        endcase
                    end
                    PH_ADDR: begin
                        s_d.addr = addr_new;
                        if (s_q.acnt != 2'd0) begin
                            s_d.acnt = s_q.acnt - 1'b1;
                        end else begin
                            raddr = addr_new[AW-1:0];
                            case (s_q.op)
                                CMD_READ: begin
                                    s_d.phase = PH_DOUT; s_d.src = SRC_MEM;
                                    s_d.tx = rdata; s_d.ptr = raddr + 1'b1;
                                end
                                CMD_FAST: begin
                                    s_d.phase = PH_DUMMY; s_d.ptr = raddr;
                                end
                                CMD_PROG: begin
                                    s_d.phase = PH_DIN; s_d.col = addr_new[7:0];
                                end
                                default: s_d.phase = PH_HOLD;
                            endcase
                        end
                    end
                    PH_DUMMY: begin
                        s_d.phase = PH_DOUT; s_d.src = SRC_MEM;
                        s_d.tx = rdata; s_d.ptr = s_q.ptr + 1'b1;
                    end
                    PH_DOUT: begin
                        case (s_q.src)
                            SRC_STAT: s_d.tx = status;
                            SRC_ID: begin
                                s_d.tx  = id_byte(s_q.idn);
                                s_d.idn = (s_q.idn == 2'd3) ? 2'd3 : s_q.idn + 1'b1;
                            end
                            default: begin
                                s_d.tx = rdata; s_d.ptr = s_q.ptr + 1'b1;
                            end
                        endcase
                    end
                    PH_DIN: begin
                        pb_we   = 1'b1;
                        s_d.col = s_q.col + 1'b1;
                        s_d.got = 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{phase: PH_OPC, src: SRC_MEM, default: '0};
        else        s_q <= s_d;
    end

    assign spi_miso = (s_q.phase == PH_DOUT) ? s_q.tx[7] : 1'b0;
    assign wel_w    = s_q.wel;
endmodule

// File: rtl/flash_resp_chk.sv
module flash_resp_chk #(
    parameter int BUSY_CLKS = 1000
) (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic miso,
    input logic wel,
    input logic busy,
    input logic start
);
    logic [31:0] busy_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    busy_len <= '0;
        else if (busy) busy_len <= busy_len + 1'b1;
        else           busy_len <= '0;
    end

    // R1: data-out stays low while select is released
    p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n) && $past(cs_n, 2)) |=> !miso);

    // R10: a job only starts with the latch set
    p_start_needs_wel_r10: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> wel);

    // R10: latch is clear by the time busy rises
    p_wel_cleared_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !wel);

    // R11: no job starts while busy
    p_no_start_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);

    // R11: busy lasts at least the minimum time
    p_busy_min_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> busy_len >= BUSY_CLKS);
endmodule

bind flash_resp flash_resp_chk #(.BUSY_CLKS(BUSY_CLKS)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(spi_cs_n), .miso(spi_miso),
    .wel(wel_w), .busy(busy), .start(start)
);

// File: tb/sim_flash_resp.sv
module sim_flash_resp;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0;
    logic cs_n = 1'b1;
    logic mosi = 1'b0;
    logic miso;
    int   checks = 0;
    int   errors = 0;
    bit   done = 0;

    always #4 clk = ~clk;

    flash_resp u0 (
        .clk(clk), .rst_n(rst_n), .spi_clk(sclk), .spi_cs_n(cs_n),
        .spi_mosi(mosi), .spi_miso(miso)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic sel_on();
        @(negedge clk) cs_n = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic sel_off();
        @(negedge clk) cs_n = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic xfer(input logic [7:0] o, output logic [7:0] i);
        for (int b = 7; b >= 0; b--) begin
            @(negedge clk) mosi = o[b];
            repeat (3) @(negedge clk);
            i[b] = miso;
            sclk = 1'b1;
            repeat (4) @(negedge clk);
            sclk = 1'b0;
        end
    endtask

    task automatic send(input logic [7:0] o);
        logic [7:0] dummy;
        xfer(o, dummy);
    endtask

    task automatic simple(input logic [7:0] op);
        sel_on(); send(op); sel_off();
    endtask

    task automatic get_status(output logic [7:0] st);
        sel_on(); send(8'h05); xfer(8'h00, st); sel_off();
    endtask

    task automatic wait_ready();
        logic [7:0] st;
        for (int n = 0; n < 200; n++) begin
            get_status(st);
            if (!st[0]) break;
        end
    endtask

    task automatic read1(input logic [23:0] a, output logic [7:0] d);
        sel_on(); send(8'h03); send(a[23:16]); send(a[15:8]); send(a[7:0]);
        xfer(8'h00, d); sel_off();
    endtask

    task automatic prog(input logic [23:0] a, input logic [7:0] d);
        simple(8'h06);
        sel_on(); send(8'h02); send(a[23:16]); send(a[15:8]); send(a[7:0]);
        send(d); sel_off();
    endtask

    task automatic t_reset();
        logic [7:0] d, e;
        check("R1 miso idle", {7'b0, miso}, 8'h00);
        get_status(d);
        check("R1 R5 status after reset", d, 8'h00);
        sel_on(); send(8'h03); send(8'h00); send(8'h00); send(8'h00);
        xfer(8'h00, d); xfer(8'h00, e); sel_off();
        check("R1 R3 blank byte 0", d, 8'hFF);
        check("R1 R3 blank byte 1", e, 8'hFF);
    endtask

    task automatic t_latch();
        logic [7:0] d, e;
        simple(8'h06);
        sel_on(); send(8'h05); xfer(8'h00, d); xfer(8'h00, e); sel_off();
        check("R6 R5 latch set", d, 8'h02);
        check("R5 status repeats", e, 8'h02);
        simple(8'h04);
        get_status(d);
        check("R6 latch cleared", d, 8'h00);
    endtask

    task automatic t_program();
        logic [7:0] d, a, b, c, f;
        sel_on(); send(8'h02); send(8'h00); send(8'h00); send(8'h10); send(8'hA5); sel_off();
        read1(24'h000010, d);
        check("R10 program without latch ignored", d, 8'hFF);
        simple(8'h06);
        sel_on(); send(8'h02); send(8'h00); send(8'h00); send(8'h10);
        send(8'hA5); send(8'h3C); sel_off();
        get_status(d);
        check("R11 busy after commit", d, 8'h01);
        wait_ready();
        get_status(d);
        check("R10 latch cleared by commit", d, 8'h00);
        sel_on(); send(8'h03); send(8'h00); send(8'h00); send(8'h0F);
        xfer(0, a); xfer(0, b); xfer(0, c); xfer(0, f); sel_off();
        check("R3 stream 0x00F", a, 8'hFF);
        check("R2 R8 stream 0x010", b, 8'hA5);
        check("R3 R8 stream 0x011", c, 8'h3C);
        check("R3 stream 0x012", f, 8'hFF);
        prog(24'h000010, 8'h0F); wait_ready();
        read1(24'h000010, d);
        check("R8 program ANDs", d, 8'h05);
        prog(24'h000090, 8'h11); wait_ready();
        prog(24'h000200, 8'h22); wait_ready();
    endtask

    task automatic t_busy_ignore();
        logic [7:0] d;
        prog(24'h000300, 8'h00);
        prog(24'h000301, 8'h00);
        wait_ready();
        read1(24'h000301, d);
        check("R11 program while busy ignored", d, 8'hFF);
        get_status(d);
        check("R11 latch kept after ignored program", d, 8'h02);
        simple(8'h04);
    endtask

    task automatic t_wrap();
        logic [7:0] d, e;
        simple(8'h06);
        sel_on(); send(8'h02); send(8'h00); send(8'h01); send(8'hFE);
        for (int i = 0; i < 258; i++) send(8'(i) + ((i >= 256) ? 8'h40 : 8'h00));
        sel_off();
        wait_ready();
        sel_on(); send(8'h03); send(8'h00); send(8'h01); send(8'hFE);
        xfer(0, d); xfer(0, e); sel_off();
        check("R8 last 256 kept col FE", d, 8'h40);
        check("R8 last 256 kept col FF", e, 8'h41);
        read1(24'h000100, d);
        check("R8 column wraps to 0", d, 8'h02);
        read1(24'h0001FD, d);
        check("R8 column FD", d, 8'hFF);
    endtask

    task automatic t_fast();
        logic [7:0] d, e;
        sel_on(); send(8'h0B); send(8'h00); send(8'h00); send(8'h10); send(8'h00);
        xfer(0, d); xfer(0, e); sel_off();
        check("R4 fast read first", d, 8'h05);
        check("R4 fast read second", e, 8'h3C);
    endtask

    task automatic t_ident();
        logic [7:0] b [4];
        sel_on(); send(8'h9F);
        for (int i = 0; i < 4; i++) xfer(0, b[i]);
        sel_off();
        check("R13 id byte 0", b[0], 8'h5A);
        check("R13 id byte 1", b[1], 8'h31);
        check("R13 id byte 2", b[2], 8'h0A);
        check("R13 id tail", b[3], 8'h00);
    endtask

    task automatic t_abort();
        logic [7:0] d;
        simple(8'h06);
        sel_on(); send(8'h02); send(8'h00); send(8'h00); send(8'h20); send(8'h00);
        for (int b = 0; b < 3; b++) begin
            @(negedge clk) mosi = 1'b0;
            repeat (3) @(negedge clk); sclk = 1'b1;
            repeat (4) @(negedge clk); sclk = 1'b0;
        end
        sel_off();
        get_status(d);
        check("R12 abort keeps latch, no busy", d, 8'h02);
        read1(24'h000020, d);
        check("R12 aborted program not stored", d, 8'hFF);
        simple(8'h04);
    endtask

    task automatic t_wide();
        logic [7:0] d;
        simple(8'hB7);
        sel_on(); send(8'h03); send(8'h00); send(8'h00); send(8'h00); send(8'h10);
        xfer(0, d); sel_off();
        check("R7 four byte read", d, 8'h05);
        simple(8'h06);
        sel_on(); send(8'h20); send(8'h00); send(8'h00); send(8'h40); sel_off();
        get_status(d);
        check("R7 subsector takes three bytes", d, 8'h01);
        wait_ready();
        sel_on(); send(8'h03); send(8'h00); send(8'h00); send(8'h00); send(8'h10);
        xfer(0, d); sel_off();
        check("R9 subsector erased", d, 8'hFF);
        simple(8'hE9);
        read1(24'h000090, d);
        check("R7 R9 three byte read, outside subsector", d, 8'h11);
    endtask

    task automatic t_erase();
        logic [7:0] d;
        simple(8'h06);
        sel_on(); send(8'hD8); send(8'h00); send(8'h00); send(8'hA0); sel_off();
        wait_ready();
        read1(24'h000090, d);
        check("R9 sector erased low", d, 8'hFF);
        read1(24'h0001FE, d);
        check("R9 sector erased high", d, 8'hFF);
        read1(24'h000200, d);
        check("R9 next sector kept", d, 8'h22);
        simple(8'h06); simple(8'hC7); wait_ready();
        read1(24'h000200, d);
        check("R9 bulk erased 0x200", d, 8'hFF);
        read1(24'h000300, d);
        check("R9 bulk erased 0x300", d, 8'hFF);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_latch();
        t_program();
        t_busy_ignore();
        t_wrap();
        t_fast();
        t_ident();
        t_abort();
        t_wide();
        t_erase();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule